// File: doc/BRIEF.md
# Rotating Capacitor Bank Switch Controller

This block decides, at each decision strobe, whether a reactive-power compensation bank needs one more capacitor group connected or one group released. It compares a measured power-factor code with a programmable setpoint. A programmable deadband around the setpoint suppresses action near the target. The result is one enable line per group, plus a one-cycle pulse that marks each connect and each disconnect.

In rotation mode the block keeps an ordered record of which groups are connected. The group that has been on longest is released first. New connections are searched circularly from just past the last group connected. Over time this spreads on-time and switch wear evenly across the whole bank. A sequential mode is also provided: groups connect lowest index first and are released most-recent first. Each released group is then held off from reconnection for a programmable number of strobes, so that it can discharge.

Top module: `capbank_rotator`

## Requirements
- R1: At a strobe with pfMeas + pfMargin < pfSetpoint, exactly one eligible idle group is connected. Its groupEn bit and insertPulse appear in the cycle after the strobe edge. insertPulse lasts one cycle.
- R2: At a strobe with pfMeas > pfSetpoint + pfMargin and at least one group on, exactly one group is released. Its groupEn bit clears and removePulse pulses one cycle, in the cycle after the strobe edge.
- R3: With rotateMode = 1, the released group is the one connected earliest among those on. The connect search starts at the index following the group most recently connected (modulo the group count) and wraps around.
- R4: With rotateMode = 0, the connect search always starts at index 0, and the released group is the one connected most recently.
- R5: A connect request with no eligible idle group changes nothing and pulses nothing; this includes the case where every group is on. A release request with no group on also changes nothing and pulses nothing.
- R6: Each strobe causes at most one action. With decideStb low, groupEn stays unchanged and both pulses stay low.
- R7: When pfSetpoint - pfMargin <= pfMeas <= pfSetpoint + pfMargin at a strobe, nothing changes. Both bounds are inclusive.
- R8: A released group is not eligible for the next holdOff strobes after its release strobe. It becomes eligible again at the strobe after those. The search skips it while it waits.
- R9: A synchronous reset (rst high at a clock edge) clears all enables, empties the connection record, zeroes the search start and clears all hold-off counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pfMeas | input | PF_W | Measured power-factor code |
| pfSetpoint | input | PF_W | Target power-factor code |
| pfMargin | input | PF_W | Half-width of the deadband |
| holdOff | input | HOLD_W | Strobes a released group must wait before it may reconnect |
| rotateMode | input | 1 | 1 = rotation (oldest out), 0 = sequential (newest out) |
| decideStb | input | 1 | One-cycle decision strobe |
| groupEn | output | GROUPS | Per-group connect enable |
| insertPulse | output | 1 | One-cycle pulse on a connect |
| removePulse | output | 1 | One-cycle pulse on a release |

## Verification
Every result of a strobe (enable change, insert pulse, release pulse) is registered once, so it is due in the cycle that follows the strobe edge. Hold-off counts advance only on strobes, not on clock cycles. The bench raises the strobe on a falling edge and lets one rising edge pass. It compares groupEn and both pulses on the next falling edge, then checks one cycle later that the pulses have gone low again. A bench-side model predicts each step from the requirements. That model keeps the connection order, the search start and the hold-off counts. It is stepped through fill, overflow, drain, both modes, deadband boundaries and a long pseudo-random sweep with mode changes.

// File: rtl/capbank_pkg.sv
package capbank_pkg;
  // strobes from the decision logic to the state keeping datapath
  typedef struct packed {
    logic stb;        // a decision strobe is being processed
    logic doInsert;   // connect the selected idle group
    logic doRemove;   // release the selected connected group
    logic popNewest;  // release takes the newest entry (sequential mode)
  } bank_cmd_t;
endpackage

// File: rtl/capbank_ctrl.sv
module capbank_ctrl #(
  parameter int GROUPS = 8,
  parameter int PF_W   = 10,
  parameter int IDX_W  = 3,
  parameter int CNT_W  = 4
) (
  input  logic                   decideStb,
  input  logic                   rotateMode,
  input  logic [PF_W-1:0]        pfMeas,
  input  logic [PF_W-1:0]        pfSetpoint,
  input  logic [PF_W-1:0]        pfMargin,
  input  logic [GROUPS-1:0]      eligible,
  input  logic [IDX_W-1:0]       scanPtr,
  input  logic [IDX_W-1:0]       headIdx,
  input  logic [IDX_W-1:0]       newestIdx,
  input  logic [CNT_W-1:0]       onCount,
  output capbank_pkg::bank_cmd_t cmd,
  output logic [IDX_W-1:0]       insIdx,
  output logic [IDX_W-1:0]       remIdx
);
  logic [PF_W:0] measPlusMargin;
  logic [PF_W:0] setPlusMargin;
  logic          lowPf;
  logic          highPf;
  logic          found;
  logic [IDX_W-1:0] pick;

  // one extra bit keeps the sums from wrapping
  assign measPlusMargin = {1'b0, pfMeas} + {1'b0, pfMargin};
  assign setPlusMargin  = {1'b0, pfSetpoint} + {1'b0, pfMargin};
  assign lowPf  = measPlusMargin < {1'b0, pfSetpoint};
  assign highPf = {1'b0, pfMeas} > setPlusMargin;

  // circular search for the first eligible idle group
  always_comb begin
    int startIdx;
    found    = 1'b0;
    pick     = '0;
    startIdx = rotateMode ? int'(scanPtr) : 0;
    for (int k = 0; k < GROUPS; k++) begin
      int idx;
      idx = startIdx + k;
      if (idx >= GROUPS) idx = idx - GROUPS;
      if (!found && eligible[idx]) begin
        found = 1'b1;
        pick  = IDX_W'(idx);
      end
    end
  end

  assign cmd.stb       = decideStb;
  assign cmd.doInsert  = decideStb && lowPf && found;
  assign cmd.doRemove  = decideStb && highPf && (onCount != '0);
  assign cmd.popNewest = !rotateMode;
  assign insIdx        = pick;
  assign remIdx        = rotateMode ? headIdx : newestIdx;
endmodule

// File: rtl/capbank_dpath.sv
module capbank_dpath #(
  parameter int GROUPS = 8,
  parameter int IDX_W  = 3,
  parameter int CNT_W  = 4,
  parameter int HOLD_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  capbank_pkg::bank_cmd_t cmd,
  input  logic [IDX_W-1:0]       insIdx,
  input  logic [IDX_W-1:0]       remIdx,
  input  logic [HOLD_W-1:0]      holdOff,
  output logic [GROUPS-1:0]      groupEn,
  output logic                   insertPulse,
  output logic                   removePulse,
  output logic [GROUPS-1:0]      eligible,
  output logic [IDX_W-1:0]       scanPtr,
  output logic [IDX_W-1:0]       headIdx,
  output logic [IDX_W-1:0]       newestIdx,
  output logic [CNT_W-1:0]       onCount
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(GROUPS - 1);

  logic [IDX_W-1:0] order [GROUPS];
  logic [IDX_W-1:0] head;
  logic [IDX_W-1:0] tail;
  logic [IDX_W-1:0] tailPrev;
  logic [IDX_W-1:0] insNext;

  function automatic logic [IDX_W-1:0] stepUp(input logic [IDX_W-1:0] p);
    return (p == LAST) ? '0 : p + IDX_W'(1);
  endfunction

  function automatic logic [IDX_W-1:0] stepDown(input logic [IDX_W-1:0] p);
    return (p == '0) ? LAST : p - IDX_W'(1);
  endfunction

  assign tailPrev  = stepDown(tail);
  assign insNext   = stepUp(insIdx);
  assign headIdx   = order[head];
  assign newestIdx = order[tailPrev];

  // per-group enable and hold-off counter
  for (genvar g = 0; g < GROUPS; g++) begin : gGroup
    logic [HOLD_W-1:0] holdCnt;
    logic              hitIns;
    logic              hitRem;
    assign hitIns = cmd.doInsert && (insIdx == IDX_W'(g));
    assign hitRem = cmd.doRemove && (remIdx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        groupEn[g] <= 1'b0;
        holdCnt    <= '0;
      end else begin
        if (hitIns) groupEn[g] <= 1'b1;
        else if (hitRem) groupEn[g] <= 1'b0;
        if (hitRem) holdCnt <= holdOff;
        else if (cmd.stb && holdCnt != '0) holdCnt <= holdCnt - HOLD_W'(1);
      end
    end

    assign eligible[g] = !groupEn[g] && (holdCnt == '0);
  end

  // ordered record of connected groups: oldest at head, newest before tail
  always_ff @(posedge clk) begin
    if (rst) begin
      head    <= '0;
      tail    <= '0;
      onCount <= '0;
      scanPtr <= '0;
      for (int i = 0; i < GROUPS; i++) order[i] <= '0;
    end else if (cmd.doInsert) begin
      order[tail] <= insIdx;
      tail        <= stepUp(tail);
      onCount     <= onCount + CNT_W'(1);
      scanPtr     <= insNext;
    end else if (cmd.doRemove) begin
      if (cmd.popNewest) tail <= tailPrev;
      else               head <= stepUp(head);
      onCount <= onCount - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      insertPulse <= 1'b0;
      removePulse <= 1'b0;
    end else begin
      insertPulse <= cmd.doInsert;
      removePulse <= cmd.doRemove;
    end
  end
endmodule

// File: rtl/capbank_rotator.sv
module capbank_rotator #(
  parameter int GROUPS = 8,
  parameter int PF_W   = 10,
  parameter int HOLD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PF_W-1:0]   pfMeas,
  input  logic [PF_W-1:0]   pfSetpoint,
  input  logic [PF_W-1:0]   pfMargin,
  input  logic [HOLD_W-1:0] holdOff,
  input  logic              rotateMode,
  input  logic              decideStb,
  output logic [GROUPS-1:0] groupEn,
  output logic              insertPulse,
  output logic              removePulse
);
  localparam int IDX_W = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam int CNT_W = $clog2(GROUPS + 1);

  capbank_pkg::bank_cmd_t cmd;
  logic [IDX_W-1:0]  insIdx;
  logic [IDX_W-1:0]  remIdx;
  logic [GROUPS-1:0] eligible;
  logic [IDX_W-1:0]  scanPtr;
  logic [IDX_W-1:0]  headIdx;
  logic [IDX_W-1:0]  newestIdx;
  logic [CNT_W-1:0]  onCount;

  capbank_ctrl #(.GROUPS(GROUPS), .PF_W(PF_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) uCtrl (
    .decideStb(decideStb), .rotateMode(rotateMode), .pfMeas(pfMeas),
    .pfSetpoint(pfSetpoint), .pfMargin(pfMargin), .eligible(eligible),
    .scanPtr(scanPtr), .headIdx(headIdx), .newestIdx(newestIdx),
    .onCount(onCount), .cmd(cmd), .insIdx(insIdx), .remIdx(remIdx)
  );

  capbank_dpath #(.GROUPS(GROUPS), .IDX_W(IDX_W), .CNT_W(CNT_W), .HOLD_W(HOLD_W)) uDpath (
    .clk(clk), .rst(rst), .cmd(cmd), .insIdx(insIdx), .remIdx(remIdx),
    .holdOff(holdOff), .groupEn(groupEn), .insertPulse(insertPulse),
    .removePulse(removePulse), .eligible(eligible), .scanPtr(scanPtr),
    .headIdx(headIdx), .newestIdx(newestIdx), .onCount(onCount)
  );
endmodule

// File: rtl/capbank_rotator_chk.sv
module capbank_rotator_chk #(
  parameter int GROUPS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              decideStb,
  input logic [GROUPS-1:0] groupEn,
  input logic              insertPulse,
  input logic              removePulse
);
  AST_SINGLE_ACTION: assert property (@(posedge clk) disable iff (rst)
    !(insertPulse && removePulse)); // R6

  AST_NO_STROBE_NO_ACTION: assert property (@(posedge clk) disable iff (rst)
    !decideStb |=> !insertPulse && !removePulse); // R6

  AST_INSERT_ADDS_ONE: assert property (@(posedge clk) disable iff (rst)
    insertPulse |-> $countones(groupEn) == $countones($past(groupEn)) + 1); // R1

  AST_REMOVE_DROPS_ONE: assert property (@(posedge clk) disable iff (rst)
    removePulse |-> $countones(groupEn) + 1 == $countones($past(groupEn))); // R2

  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !insertPulse && !removePulse |-> $stable(groupEn)); // R5

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> groupEn == '0); // R9
endmodule

bind capbank_rotator capbank_rotator_chk #(.GROUPS(GROUPS)) uChk (
  .clk(clk), .rst(rst), .decideStb(decideStb), .groupEn(groupEn),
  .insertPulse(insertPulse), .removePulse(removePulse)
);

// File: tb/capbank_rotator_test.sv
module capbank_rotator_test;
  localparam int G = 8;
  localparam int PF_W = 10;
  localparam int HOLD_W = 4;
  localparam int SETP = 500;
  localparam int MARG = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [PF_W-1:0]   pfMeas = '0;
  logic [PF_W-1:0]   pfSetpoint = PF_W'(SETP);
  logic [PF_W-1:0]   pfMargin = PF_W'(MARG);
  logic [HOLD_W-1:0] holdOff = '0;
  logic              rotateMode = 1'b1;
  logic              decideStb = 1'b0;
  logic [G-1:0]      groupEn;
  logic              insertPulse;
  logic              removePulse;

  int checks = 0;
  int errors = 0;

  // reference state
  bit mEn [G];
  int mHold [G];
  int mOrder [$];
  int mScan = 0;

  always #5 clk = ~clk;

  capbank_rotator #(.GROUPS(G), .PF_W(PF_W), .HOLD_W(HOLD_W)) uut (
    .clk(clk), .rst(rst), .pfMeas(pfMeas), .pfSetpoint(pfSetpoint),
    .pfMargin(pfMargin), .holdOff(holdOff), .rotateMode(rotateMode),
    .decideStb(decideStb), .groupEn(groupEn), .insertPulse(insertPulse),
    .removePulse(removePulse)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [G-1:0] modelVec();
    logic [G-1:0] v = '0;
    for (int i = 0; i < G; i++) v[i] = mEn[i];
    return v;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < G; i++) begin mEn[i] = 0; mHold[i] = 0; end
    mOrder.delete();
    mScan = 0;
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    modelReset();
    check(groupEn == '0, "R9", "enables after reset", groupEn, 0);
    check(!insertPulse && !removePulse, "R9", "pulses after reset",
          {insertPulse, removePulse}, 0);
  endtask

  // one decision strobe, model prediction, and port comparison
  task automatic step(input int pf, input bit rot);
    bit lo, hi, found, expIns, expRem, holding;
    int start, pick, r;
    string tag;
    lo = (pf + MARG) < SETP;
    hi = pf > (SETP + MARG);
    start = rot ? mScan : 0;
    found = 0; pick = 0; holding = 0;
    for (int i = 0; i < G; i++) if (mHold[i] > 0) holding = 1;
    for (int k = 0; k < G; k++) begin
      int idx;
      idx = (start + k) % G;
      if (!found && !mEn[idx] && mHold[idx] == 0) begin found = 1; pick = idx; end
    end
    expIns = lo && found;
    expRem = hi && (mOrder.size() > 0);
    if (!lo && !hi) tag = "R7";
    else if (lo && !found) tag = (mOrder.size() == G) ? "R5" : "R8 R5";
    else if (hi && !expRem) tag = "R5";
    else if (lo) tag = rot ? "R1 R3" : "R1 R4";
    else tag = rot ? "R2 R3" : "R2 R4";
    if (holding) tag = {tag, " R8"};
    for (int i = 0; i < G; i++) if (mHold[i] > 0) mHold[i]--;
    if (expIns) begin
      mEn[pick] = 1; mOrder.push_back(pick); mScan = (pick + 1) % G;
    end
    if (expRem) begin
      r = rot ? mOrder.pop_front() : mOrder.pop_back();
      mEn[r] = 0; mHold[r] = int'(holdOff);
    end
    @(negedge clk);
    pfMeas = PF_W'(pf); rotateMode = rot; decideStb = 1'b1;
    @(negedge clk);
    decideStb = 1'b0;
    check(groupEn == modelVec(), tag, "groupEn", groupEn, modelVec());
    check(insertPulse == expIns, tag, "insertPulse", insertPulse, expIns);
    check(removePulse == expRem, tag, "removePulse", removePulse, expRem);
    @(negedge clk);
    check(!insertPulse && !removePulse, "R6", "pulse width",
          {insertPulse, removePulse}, 0);
  endtask

  localparam int LOWPF = 400;
  localparam int HIGHPF = 600;

  initial begin : watchdog
    #1_000_000;
    errors++;
    $display("FAIL R6 watchdog expired: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] lfsr;
    logic [G-1:0] snap;
    bit rot;
    int sel, pf;
    modelReset();
    doReset();

    // rotation: fill, overflow, partial drain, refill, deadband edges
    holdOff = '0;
    for (int i = 0; i < G + 1; i++) step(LOWPF, 1);
    for (int i = 0; i < 3; i++) step(HIGHPF, 1);
    step(LOWPF, 1); step(LOWPF, 1);
    step(HIGHPF, 1);
    step(SETP - MARG, 1); step(SETP + MARG, 1); step(SETP, 1);
    step(SETP - MARG - 1, 1); step(SETP + MARG + 1, 1);
    for (int i = 0; i < G + 2; i++) step(HIGHPF, 1);

    // sequential mode
    for (int i = 0; i < 5; i++) step(LOWPF, 0);
    step(HIGHPF, 0); step(HIGHPF, 0);
    for (int i = 0; i < 3; i++) step(LOWPF, 0);

    // no strobe: nothing may move
    snap = groupEn;
    @(negedge clk); pfMeas = PF_W'(LOWPF);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(groupEn == snap && !insertPulse && !removePulse, "R6",
            "no strobe", groupEn, snap);
    end

    // hold-off and mixed modes, pseudo-random sweep
    holdOff = HOLD_W'(2);
    lfsr = 16'hACE1;
    rot = 1;
    for (int n = 0; n < 320; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sel = int'(lfsr[2:0]);
      case (sel)
        0, 1, 2: pf = LOWPF;
        3, 4:    pf = HIGHPF;
        5:       pf = SETP - MARG - 1;
        6:       pf = SETP + MARG + 1;
        default: pf = SETP - MARG + int'(lfsr[5:3]);
      endcase
      if (n % 37 == 36) rot = !rot;
      step(pf, rot);
    end

    // hold-off sweep of a single group in sequential mode
    doReset();
    holdOff = HOLD_W'(3);
    step(LOWPF, 0); step(HIGHPF, 0);
    for (int i = 0; i < 5; i++) begin step(LOWPF, 0); step(HIGHPF, 0); end

    // reset mid-run, then rotation restarts at group 0
    step(LOWPF, 1); step(LOWPF, 1);
    doReset();
    holdOff = '0;
    step(LOWPF, 1);
    check(groupEn == G'(1), "R9 R3", "first group after reset", groupEn, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule